// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block owns an SDRAM command bus from the moment synchronous reset lets go until the memory can accept ordinary traffic. It first holds the device quiet, with clock enable and data mask high and a no-operation code on the command strobes. That quiet stretch lasts a stabilization time derived from a clock-frequency parameter. The block then closes every bank, runs a configurable number of auto-refresh cycles and loads the mode register. Between commands it enforces a minimum spacing and drives no-operation while it waits.

The mode word placed on the address bus is assembled at elaboration from encoded fields: burst length, burst type, read latency and write-burst policy. Test-mode and reserved positions are forced low. A parameter picks whether the refresh group runs before or after the mode load, because the device accepts either order. Parameter sets the device cannot accept are refused at elaboration. Once the last spacing window has expired, `init_done` rises and stays high. The bus then rests at no-operation until a synchronous reset restarts the whole sequence. Every pin is a plain control level, and there is no streaming interface.

Top module: `sdram_init_seq`

## Requirements
- R1: From the first cycle after reset is released, `cke` and `dqm` are high and the strobes {cs_n,ras_n,cas_n,we_n} read 0111 (no-operation). No other code appears until exactly STABLE_US*CLK_MHZ cycles have elapsed.
- R2: The first command is bank-close-all, strobes 0010, with address bit 10 high. It appears on cycle STABLE_US*CLK_MHZ after reset release.
- R3: Exactly REFRESH_COUNT auto-refresh commands (strobes 0001) are issued per sequence, and REFRESH_COUNT is at least 2.
- R4: With REFRESH_FIRST=1 the refreshes precede the mode load (strobes 0000). With REFRESH_FIRST=0 the mode load directly follows bank-close and the refreshes follow it.
- R5: A command issued on cycle c is followed by the next one on cycle c+T_RP after bank-close, c+T_RC after a refresh and c+T_MRD after a mode load. Only no-operation is driven in between.
- R6: During the mode load, addr[2:0] carries the burst-length code (1→000, 2→001, 4→010, 8→011, full page of 256→111) and addr[3] carries the burst type (0 sequential, 1 interleave).
- R7: During the mode load, addr[6:4] carries the read latency (2→010, 3→011), and addr[9] equals WRITE_SINGLE (1 = reads burst, writes touch one location).
- R8: During the mode load, `ba`, addr[8:7] and every address bit above 9 are zero.
- R9: `init_done` rises exactly one spacing window after the last command. It then stays high, and the strobes stay at no-operation.
- R10: A synchronous reset at any point, including a command cycle, leaves no-operation and `init_done` low on the next cycle. It restarts the full stabilization count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | output | 1 | Chip select strobe, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write-enable strobe, active low |
| cke | output | 1 | Clock enable, held high |
| dqm | output | 1 | Data mask, held high |
| ba | output | BA_W | Bank address, zero throughout |
| addr | output | ADDR_W | Address bus: bit 10 during bank-close, mode word during mode load |
| init_done | output | 1 | Sequence finished; sticky until reset |

## Verification
The two functions that can land in the same cycle are the synchronous restart and a command issue. The sharpest case is reset arriving while the mode load is on the bus, the cycle after which the sequencer would otherwise enter its final spacing window. The bench counts up to that exact mode-load cycle and raises reset on it. It then requires no-operation and a low `init_done` on the following cycle. It also requires a full, unshortened stabilization count before bank-close reappears. A second instance, built with the reverse order, full-page bursts and a longer refresh group, shows that command order, spacing and mode-word fields follow their parameters.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

  typedef enum logic [3:0] {
    CMD_MODE = 4'b0000,
    CMD_AREF = 4'b0001,
    CMD_PALL = 4'b0010,
    CMD_NOP  = 4'b0111
  } sdr_cmd_e;

  typedef enum logic [2:0] {
    PH_STABLE,
    PH_PALL,
    PH_AREF,
    PH_MODE,
    PH_WAIT,
    PH_DONE
  } init_phase_e;

  localparam int FULL_PAGE_LEN = 256;

  function automatic logic [2:0] burst_code(input int len);
    case (len)
      1:             burst_code = 3'b000;
      2:             burst_code = 3'b001;
      4:             burst_code = 3'b010;
      8:             burst_code = 3'b011;
      FULL_PAGE_LEN: burst_code = 3'b111;
      default:       burst_code = 3'b000;
    endcase
  endfunction

  function automatic bit burst_len_legal(input int len);
    burst_len_legal = (len == 1) || (len == 2) || (len == 4) ||
                      (len == 8) || (len == FULL_PAGE_LEN);
  endfunction

endpackage

// File: rtl/sdr_mode_word.sv
module sdr_mode_word #(
  parameter int ADDR_W           = 12,
  parameter int BURST_LEN        = 4,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int CAS_LAT          = 2,
  parameter bit WRITE_SINGLE     = 1'b0
) (
  output logic [ADDR_W-1:0] word
);
  import sdram_init_pkg::*;

  localparam logic [2:0] BL_BITS  = burst_code(BURST_LEN);
  localparam logic [2:0] LAT_BITS = 3'(CAS_LAT);

  generate
    if (ADDR_W < 11) begin : g_bad_width
      $error("sdr_mode_word: address bus must reach bit 10");
    end
    if (!burst_len_legal(BURST_LEN)) begin : g_bad_len
      $error("sdr_mode_word: burst length must be 1, 2, 4, 8 or 256");
    end
    if (BURST_LEN == FULL_PAGE_LEN && BURST_INTERLEAVE) begin : g_bad_mix
      $error("sdr_mode_word: full-page burst requires sequential type");
    end
    if (CAS_LAT < 2 || CAS_LAT > 3) begin : g_bad_lat
      $error("sdr_mode_word: read latency must be 2 or 3");
    end
  endgenerate

  always_comb begin
    word      = '0;
    word[2:0] = BL_BITS;
    word[3]   = BURST_INTERLEAVE;
    word[6:4] = LAT_BITS;
    word[9]   = WRITE_SINGLE;
  end

endmodule

// File: rtl/sdr_wait_timer.sv
module sdr_wait_timer #(
  parameter int CW      = 16,
  parameter int RST_VAL = 100
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);
  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)
      cnt <= CW'(RST_VAL);
    else if (load)
      cnt <= load_val;
    else if (cnt != '0)
      cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

endmodule

// File: rtl/sdr_init_ctrl.sv
module sdr_init_ctrl #(
  parameter int CW            = 16,
  parameter int REFRESH_COUNT = 2,
  parameter bit REFRESH_FIRST = 1'b1,
  parameter int T_RP          = 3,
  parameter int T_RC          = 7,
  parameter int T_MRD         = 2
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          tmr_zero,
  output logic                          tmr_load,
  output logic [CW-1:0]                 tmr_val,
  output sdram_init_pkg::sdr_cmd_e      cmd,
  output logic                          done
);
  import sdram_init_pkg::*;

  localparam int RW = $clog2(REFRESH_COUNT + 1);
  localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 2);
  localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 2);
  localparam logic [CW-1:0] LD_MRD = CW'(T_MRD - 2);

  generate
    if (REFRESH_COUNT < 2) begin : g_bad_refs
      $error("sdr_init_ctrl: at least two refresh commands are required");
    end
    if (T_RP < 2 || T_RC < 2 || T_MRD < 2) begin : g_bad_gap
      $error("sdr_init_ctrl: every spacing must be at least two cycles");
    end
  endgenerate

  init_phase_e    phase, phase_nx;
  init_phase_e    resume, resume_nx;
  logic [RW-1:0]  refs_left, refs_left_nx;

  always_comb begin
    phase_nx     = phase;
    resume_nx    = resume;
    refs_left_nx = refs_left;
    tmr_load     = 1'b0;
    tmr_val      = '0;
    case (phase)
      PH_STABLE: if (tmr_zero) phase_nx = PH_PALL;
      PH_PALL: begin
        tmr_load  = 1'b1;
        tmr_val   = LD_RP;
        resume_nx = REFRESH_FIRST ? PH_AREF : PH_MODE;
        phase_nx  = PH_WAIT;
      end
      PH_AREF: begin
        tmr_load     = 1'b1;
        tmr_val      = LD_RC;
        refs_left_nx = refs_left - 1'b1;
        if (refs_left != RW'(1))
          resume_nx = PH_AREF;
        else
          resume_nx = REFRESH_FIRST ? PH_MODE : PH_DONE;
        phase_nx = PH_WAIT;
      end
      PH_MODE: begin
        tmr_load  = 1'b1;
        tmr_val   = LD_MRD;
        resume_nx = REFRESH_FIRST ? PH_DONE : PH_AREF;
        phase_nx  = PH_WAIT;
      end
      PH_WAIT: if (tmr_zero) phase_nx = resume;
      PH_DONE: phase_nx = PH_DONE;
      default: phase_nx = PH_STABLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_STABLE;
      resume    <= PH_PALL;
      refs_left <= RW'(REFRESH_COUNT);
    end else begin
      phase     <= phase_nx;
      resume    <= resume_nx;
      refs_left <= refs_left_nx;
    end
  end

  always_comb begin
    case (phase)
      PH_PALL: cmd = CMD_PALL;
      PH_AREF: cmd = CMD_AREF;
      PH_MODE: cmd = CMD_MODE;
      default: cmd = CMD_NOP;
    endcase
  end

  assign done = (phase == PH_DONE);

endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq #(
  parameter int ADDR_W           = 12,
  parameter int BA_W             = 2,
  parameter int CLK_MHZ          = 100,
  parameter int STABLE_US        = 200,
  parameter int REFRESH_COUNT    = 2,
  parameter bit REFRESH_FIRST    = 1'b1,
  parameter int BURST_LEN        = 4,
  parameter bit BURST_INTERLEAVE = 1'b0,
  parameter int CAS_LAT          = 2,
  parameter bit WRITE_SINGLE     = 1'b0,
  parameter int T_RP             = 3,
  parameter int T_RC             = 7,
  parameter int T_MRD            = 2
) (
  input  logic              clk,
  input  logic              rst,
  output logic              cs_n,
  output logic              ras_n,
  output logic              cas_n,
  output logic              we_n,
  output logic              cke,
  output logic              dqm,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              init_done
);
  import sdram_init_pkg::*;

  localparam int STABLE_CYC = CLK_MHZ * STABLE_US;
  localparam int GAP_MAX    = (T_RC > T_RP) ? ((T_RC > T_MRD) ? T_RC : T_MRD)
                                            : ((T_RP > T_MRD) ? T_RP : T_MRD);
  localparam int TOP_CNT    = (STABLE_CYC > GAP_MAX) ? STABLE_CYC : GAP_MAX;
  localparam int CW         = $clog2(TOP_CNT + 1);

  generate
    if (STABLE_CYC < 1) begin : g_bad_stable
      $error("sdram_init_seq: stabilization period must be positive");
    end
  endgenerate

  logic              tmr_zero;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  sdr_cmd_e          cmd;
  logic [ADDR_W-1:0] mode_word;

  sdr_wait_timer #(
    .CW      (CW),
    .RST_VAL (STABLE_CYC - 1)
  ) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .zero     (tmr_zero)
  );

  sdr_init_ctrl #(
    .CW            (CW),
    .REFRESH_COUNT (REFRESH_COUNT),
    .REFRESH_FIRST (REFRESH_FIRST),
    .T_RP          (T_RP),
    .T_RC          (T_RC),
    .T_MRD         (T_MRD)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .tmr_zero (tmr_zero),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .cmd      (cmd),
    .done     (init_done)
  );

  sdr_mode_word #(
    .ADDR_W           (ADDR_W),
    .BURST_LEN        (BURST_LEN),
    .BURST_INTERLEAVE (BURST_INTERLEAVE),
    .CAS_LAT          (CAS_LAT),
    .WRITE_SINGLE     (WRITE_SINGLE)
  ) u_mode (
    .word (mode_word)
  );

  assign {cs_n, ras_n, cas_n, we_n} = cmd;
  assign cke = 1'b1;
  assign dqm = 1'b1;
  assign ba  = '0;

  always_comb begin
    addr = '0;
    if (cmd == CMD_MODE)
      addr = mode_word;
    else if (cmd == CMD_PALL)
      addr[10] = 1'b1;
  end

endmodule

// File: rtl/sdram_init_chk.sv
module sdram_init_chk #(
  parameter int ADDR_W     = 12,
  parameter int BA_W       = 2,
  parameter int STABLE_CYC = 20000,
  parameter int T_RP       = 3,
  parameter int T_RC       = 7,
  parameter int T_MRD      = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              ras_n,
  input logic              cas_n,
  input logic              we_n,
  input logic [BA_W-1:0]   ba,
  input logic [ADDR_W-1:0] addr,
  input logic              init_done
);
  localparam int SW = $clog2(STABLE_CYC + 1);
  localparam logic [3:0] C_NOP  = 4'b0111;
  localparam logic [3:0] C_PALL = 4'b0010;
  localparam logic [3:0] C_AREF = 4'b0001;
  localparam logic [3:0] C_MODE = 4'b0000;

  logic [3:0]    code;
  logic [SW-1:0] since_rst;
  logic [15:0]   gap;
  logic [3:0]    prev;
  logic          seen;
  int            need;

  assign code = {cs_n, ras_n, cas_n, we_n};

  always_ff @(posedge clk) begin
    if (rst) begin
      since_rst <= '0;
      gap       <= '0;
      prev      <= C_NOP;
      seen      <= 1'b0;
    end else begin
      if (since_rst != SW'(STABLE_CYC)) since_rst <= since_rst + 1'b1;
      if (code != C_NOP) begin
        gap  <= 16'd1;
        prev <= code;
        seen <= 1'b1;
      end else if (gap != 16'hFFFF) begin
        gap <= gap + 1'b1;
      end
    end
  end

  always_comb begin
    case (prev)
      C_PALL:  need = T_RP;
      C_AREF:  need = T_RC;
      C_MODE:  need = T_MRD;
      default: need = 0;
    endcase
  end

  assert_stable_nop_R1: assert property (@(posedge clk) disable iff (rst)
    (since_rst < SW'(STABLE_CYC)) |-> (code == C_NOP));

  assert_close_first_R2: assert property (@(posedge clk) disable iff (rst)
    (code != C_NOP && !seen) |-> (code == C_PALL));

  assert_close_all_R2: assert property (@(posedge clk) disable iff (rst)
    (code == C_PALL) |-> addr[10]);

  assert_min_gap_R5: assert property (@(posedge clk) disable iff (rst)
    (code != C_NOP && seen) |-> (int'(gap) >= need));

  assert_mode_clean_R8: assert property (@(posedge clk) disable iff (rst)
    (code == C_MODE) |-> (ba == '0 && addr[8:7] == 2'b00 && (addr >> 10) == '0));

  assert_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |=> init_done);

  assert_done_quiet_R9: assert property (@(posedge clk) disable iff (rst)
    init_done |-> (code == C_NOP));

endmodule

bind sdram_init_seq sdram_init_chk #(
  .ADDR_W     (ADDR_W),
  .BA_W       (BA_W),
  .STABLE_CYC (CLK_MHZ * STABLE_US),
  .T_RP       (T_RP),
  .T_RC       (T_RC),
  .T_MRD      (T_MRD)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cs_n      (cs_n),
  .ras_n     (ras_n),
  .cas_n     (cas_n),
  .we_n      (we_n),
  .ba        (ba),
  .addr      (addr),
  .init_done (init_done)
);

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;
  localparam int PERIOD = 10;
  localparam int AW = 12;
  localparam int BW = 2;

  localparam logic [3:0] NOP  = 4'b0111;
  localparam logic [3:0] PALL = 4'b0010;
  localparam logic [3:0] AREF = 4'b0001;
  localparam logic [3:0] MODE = 4'b0000;

  // instance 0: defaults, refresh group first
  localparam int S0 = 100 * 200;
  localparam int RC0 = 2, RP0 = 3, TRC0 = 7, MRD0 = 2;
  localparam bit RF0 = 1'b1;
  localparam logic [AW-1:0] MW0 = 12'h022;   // BL4, sequential, latency 2
  // instance 1: reverse order, full page, latency 3, single writes
  localparam int S1 = 10 * 200;
  localparam int RC1 = 3, RP1 = 2, TRC1 = 5, MRD1 = 3;
  localparam bit RF1 = 1'b0;
  localparam logic [AW-1:0] MW1 = 12'h237;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(PERIOD/2) clk = ~clk;

  logic cs0, ras0, cas0, we0, cke0, dqm0, done0;
  logic cs1, ras1, cas1, we1, cke1, dqm1, done1;
  logic [BW-1:0] ba0, ba1;
  logic [AW-1:0] addr0, addr1;

  sdram_init_seq u0 (
    .clk(clk), .rst(rst), .cs_n(cs0), .ras_n(ras0), .cas_n(cas0), .we_n(we0),
    .cke(cke0), .dqm(dqm0), .ba(ba0), .addr(addr0), .init_done(done0));

  sdram_init_seq #(
    .CLK_MHZ(10), .REFRESH_COUNT(RC1), .REFRESH_FIRST(RF1), .BURST_LEN(256),
    .BURST_INTERLEAVE(1'b0), .CAS_LAT(3), .WRITE_SINGLE(1'b1),
    .T_RP(RP1), .T_RC(TRC1), .T_MRD(MRD1)
  ) u1 (
    .clk(clk), .rst(rst), .cs_n(cs1), .ras_n(ras1), .cas_n(cas1), .we_n(we1),
    .cke(cke1), .dqm(dqm1), .ba(ba1), .addr(addr1), .init_done(done1));

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  int exp_cyc [0:15];
  logic [3:0] exp_cmd [0:15];
  int exp_n;
  int exp_done;

  function automatic logic [3:0] cmd_of(input int w);
    return (w == 0) ? {cs0, ras0, cas0, we0} : {cs1, ras1, cas1, we1};
  endfunction
  function automatic logic [AW-1:0] addr_of(input int w);
    return (w == 0) ? addr0 : addr1;
  endfunction
  function automatic logic [BW-1:0] ba_of(input int w);
    return (w == 0) ? ba0 : ba1;
  endfunction
  function automatic logic done_of(input int w);
    return (w == 0) ? done0 : done1;
  endfunction
  function automatic logic pins_of(input int w);
    return (w == 0) ? (cke0 & dqm0) : (cke1 & dqm1);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic build_plan(input int w);
    int s, rp, trc, mrd, rc, t;
    bit rf;
    s   = (w == 0) ? S0 : S1;     rp  = (w == 0) ? RP0 : RP1;
    trc = (w == 0) ? TRC0 : TRC1; mrd = (w == 0) ? MRD0 : MRD1;
    rc  = (w == 0) ? RC0 : RC1;   rf  = (w == 0) ? RF0 : RF1;
    exp_n = 0;
    exp_cyc[exp_n] = s; exp_cmd[exp_n] = PALL; exp_n++;
    t = s + rp;
    if (!rf) begin
      exp_cyc[exp_n] = t; exp_cmd[exp_n] = MODE; exp_n++; t += mrd;
    end
    for (int i = 0; i < rc; i++) begin
      exp_cyc[exp_n] = t; exp_cmd[exp_n] = AREF; exp_n++; t += trc;
    end
    if (rf) begin
      exp_cyc[exp_n] = t; exp_cmd[exp_n] = MODE; exp_n++; t += mrd;
    end
    exp_done = t;
  endtask

  task automatic release_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // R1, R9: outputs while reset is held
  task automatic t_reset_state();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    for (int w = 0; w < 2; w++) begin
      check(cmd_of(w) == NOP, "R1 reset strobes", cmd_of(w), NOP);
      check(pins_of(w) == 1'b1, "R1 reset cke/dqm", pins_of(w), 1);
      check(done_of(w) == 1'b0, "R9 reset init_done", done_of(w), 0);
    end
  endtask

  // R1..R9: full sequence on one instance
  task automatic t_sequence(input int w);
    int ev, pin_bad, done_at, drops, late_cmd, limit;
    logic [3:0] c;
    logic [AW-1:0] mw;
    build_plan(w);
    mw = (w == 0) ? MW0 : MW1;
    ev = 0; pin_bad = 0; done_at = -1; drops = 0; late_cmd = 0;
    limit = exp_done + 40;
    release_reset();
    for (int n = 1; n <= limit; n++) begin
      @(negedge clk);
      c = cmd_of(w);
      if (!pins_of(w)) pin_bad++;
      if (done_of(w) && done_at < 0) done_at = n;
      if (done_at >= 0 && !done_of(w)) drops++;
      if (c != NOP) begin
        if (done_at >= 0) late_cmd++;
        if (ev < exp_n) begin
          check(n == exp_cyc[ev], "R5 command cycle", n, exp_cyc[ev]);
          check(c == exp_cmd[ev], "R4 command order (R2 R3)", c, exp_cmd[ev]);
          if (c == PALL)
            check(addr_of(w)[10] == 1'b1, "R2 bank-close bit 10", addr_of(w)[10], 1);
          if (c == MODE) begin
            check(addr_of(w)[3:0] == mw[3:0], "R6 length/type field", addr_of(w)[3:0], mw[3:0]);
            check(addr_of(w)[6:4] == mw[6:4], "R7 latency field", addr_of(w)[6:4], mw[6:4]);
            check(addr_of(w)[9] == mw[9], "R7 write policy bit", addr_of(w)[9], mw[9]);
            check(addr_of(w) == mw, "R8 full mode word", addr_of(w), mw);
            check(ba_of(w) == '0, "R8 bank bits", ba_of(w), 0);
          end
        end
        ev++;
      end
    end
    check(ev == exp_n, "R3 command count", ev, exp_n);
    check(pin_bad == 0, "R1 cke/dqm high", pin_bad, 0);
    check(done_at == exp_done, "R9 init_done cycle", done_at, exp_done);
    check(drops == 0, "R9 init_done sticky", drops, 0);
    check(late_cmd == 0, "R9 quiet after done", late_cmd, 0);
  endtask

  // R10: reset on the same cycle as the mode load
  task automatic t_reset_on_mode();
    int mode_cyc, early;
    build_plan(0);
    mode_cyc = exp_cyc[exp_n-1];
    release_reset();
    for (int n = 1; n <= mode_cyc; n++) @(negedge clk);
    check(cmd_of(0) == MODE, "R10 setup at mode load", cmd_of(0), MODE);
    rst = 1'b1;
    @(negedge clk);
    check(cmd_of(0) == NOP, "R10 strobes after reset", cmd_of(0), NOP);
    check(done_of(0) == 1'b0, "R10 init_done after reset", done_of(0), 0);
    rst = 1'b0;
    early = 0;
    for (int n = 1; n < S0; n++) begin
      @(negedge clk);
      if (cmd_of(0) != NOP || done_of(0)) early++;
    end
    check(early == 0, "R10 full restart count", early, 0);
    @(negedge clk);
    check(cmd_of(0) == PALL, "R10 bank-close after restart", cmd_of(0), PALL);
  endtask

  initial begin
    t_reset_state();
    t_sequence(0);
    t_sequence(1);
    t_reset_on_mode();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(PERIOD * 190000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

endmodule